// File: doc/BRIEF.md
# ATM Cell-Mode Receive Port with Cell-Available Flag

This block is the receive half of an 8-bit cell-level port that hands ATM cells from a physical-layer device to an ATM-layer reader. Cells arrive from the upstream receive path one byte per cycle, already delineated and checked, 53 bytes each. They are held in a four-slot store. A cell becomes visible to the reader only once its last byte has been written. A cell-available flag tells the reader that a whole cell is waiting. The reader then pulls the cell out one byte per clock by holding an active-low enable. Each byte comes with a start-of-cell marker and an odd parity bit.

A small control/status byte selects the behaviour. The early-drop mode lowers the cell-available flag right after payload byte 44 of the last queued cell, not after its final byte. The shared-bus mode releases the output drivers whenever the reader's enable is high. A self-clearing flush command empties the store. A sticky status bit reports whether any cell has arrived since that byte was last read.

The read side is one state machine with three states. RD_IDLE waits with the head cell's first byte presented. RD_XFER is active while the rest of a cell is transferred. RD_FLUSH lasts one cycle and empties the store. Its transitions are as follows. The start transition goes from RD_IDLE to RD_XFER when the first byte is taken. The end-of-cell transition goes from RD_XFER back to RD_IDLE when byte 53 is taken. The flush-entry transition goes from RD_IDLE or RD_XFER to RD_FLUSH while the flush bit is 1. The flush-exit transition goes from RD_FLUSH back to RD_IDLE.

Top module: `utopia_rx_cellport`

## Requirements
- R1: After reset `cell_avail_o` is 0, `rd_oe_o` is 1 and `cfg_rdata_o` reads 0x08. The control byte has early mode at bit 0, shared-bus mode at bit 1, flush at bit 2 and the no-cell status at bit 3.
- R2: A cell raises `cell_avail_o` in the cycle after its 53rd byte is written. Fewer bytes do not raise it.
- R3: Cells leave in the order they were written, each byte unchanged. `rd_start_o` is 1 only while the first byte of a cell is presented.
- R4: `rd_par_o` makes the 9 bits {`rd_data_o`, `rd_par_o`} odd in the number of ones.
- R5: A byte is taken only at a rising edge where `rd_en_ni` is 0. While `rd_en_ni` is 1 the presented byte does not change.
- R6: With bit 0 clear, `cell_avail_o` stays 1 until the last byte of a cell is taken. It then falls if no other whole cell is queued.
- R7: With bit 0 set, `cell_avail_o` falls once byte index 48 (payload byte 44) of the last queued cell is taken. It stays 1 if another whole cell is queued.
- R8: With bit 1 set, `rd_oe_o` is 0 whenever `rd_en_ni` is 1. With bit 1 clear, `rd_oe_o` is always 1.
- R9: The store holds 4 cells. A cell whose first byte arrives while 4 cells are held is discarded whole.
- R10: Writing 1 to bit 2 reads back as 1 for two cycles and then as 0. After that the store is empty and `cell_avail_o` is 0, and `cell_avail_o` is 0 while the flush runs.
- R11: Bit 3 reads 0 if a cell has been committed since the previous status read, and 1 otherwise. A read sets it back to 1.
- R12: Flush works from RD_XFER in the middle of a cell. Afterwards the next written cell is read from its first byte in RD_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cell_wr_valid_i | input | 1 | Incoming cell byte valid |
| cell_wr_data_i | input | 8 | Incoming cell byte |
| rd_en_ni | input | 1 | Reader enable, active low |
| rd_data_o | output | 8 | Presented cell byte |
| rd_start_o | output | 1 | First byte of a cell is presented |
| rd_par_o | output | 1 | Odd parity over rd_data_o |
| rd_oe_o | output | 1 | Output driver enable for data, start and parity |
| cell_avail_o | output | 1 | A whole cell is available |
| cfg_wr_i | input | 1 | Control byte write strobe |
| cfg_rd_i | input | 1 | Status read strobe |
| cfg_wdata_i | input | 8 | Control write data |
| cfg_rdata_o | output | 8 | Control/status read data |

## Verification
The presented byte, start marker, parity and driver enable depend on the current state and inputs only. The bench checks them at the falling edge just before the edge that takes the byte. Each commit or transfer changes the cell-available flag one rising edge later, so the bench samples it at the next falling edge. A flush write reads back 1 at the next falling edge and 0 two falling edges later, and the bench checks exactly those edges. The expected bytes come from a bench function of cell number and byte index, and the flag values come from the queue depth the bench tracks itself.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_XFER  = 2'd1,
        RD_FLUSH = 2'd2
    } rd_state_e;

    localparam int unsigned CFG_EARLY_BIT  = 0;
    localparam int unsigned CFG_MULTI_BIT  = 1;
    localparam int unsigned CFG_FLUSH_BIT  = 2;
    localparam int unsigned CFG_NOCELL_BIT = 3;

endpackage

// File: rtl/utopia_rx_store.sv
module utopia_rx_store #(
    parameter int unsigned NCELLS     = 4,
    parameter int unsigned CELL_BYTES = 53,
    parameter int unsigned DW         = 8,
    localparam int unsigned SLOT_W    = $clog2(NCELLS),
    localparam int unsigned IDX_W     = $clog2(CELL_BYTES),
    localparam int unsigned CNT_W     = $clog2(NCELLS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_valid_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic              clear_i,
    input  logic              release_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DW-1:0]     rd_byte_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              commit_o
);

    localparam int unsigned DEPTH  = NCELLS * CELL_BYTES;
    localparam int unsigned ADDR_W = $clog2(DEPTH);

    logic [DW-1:0]     mem [DEPTH];
    logic [IDX_W-1:0]  wr_idx_q;
    logic [SLOT_W-1:0] wr_slot_q;
    logic              keep_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_last;
    logic              keep_now;
    logic              wr_take;

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [SLOT_W-1:0] s,
                                                    input logic [IDX_W-1:0]  i);
        return ADDR_W'(s) * ADDR_W'(CELL_BYTES) + ADDR_W'(i);
    endfunction

    always_comb begin
        wr_last  = (wr_idx_q == IDX_W'(CELL_BYTES - 1));
        keep_now = (wr_idx_q == '0) ? (cnt_q < CNT_W'(NCELLS)) : keep_q;
        wr_take  = wr_valid_i && keep_now && !clear_i;
        commit_o = wr_take && wr_last;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_idx_q  <= '0;
            wr_slot_q <= '0;
            keep_q    <= 1'b0;
            cnt_q     <= '0;
        end else if (clear_i) begin
            wr_idx_q  <= '0;
            wr_slot_q <= '0;
            keep_q    <= 1'b0;
            cnt_q     <= '0;
        end else begin
            if (wr_valid_i) begin
                keep_q   <= keep_now;
                wr_idx_q <= wr_last ? '0 : wr_idx_q + 1'b1;
                if (wr_last && keep_now) begin
                    wr_slot_q <= wr_slot_q + 1'b1;
                end
            end
            cnt_q <= cnt_q + CNT_W'(commit_o) - CNT_W'(release_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (wr_take) begin
            mem[slot_addr(wr_slot_q, wr_idx_q)] <= wr_data_i;
        end
    end

    assign rd_byte_o = mem[slot_addr(rd_slot_i, rd_idx_i)];
    assign cnt_o     = cnt_q;

    p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_W'(NCELLS))
        else $error("R9: cell count above capacity");

    p_commit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_o && !release_i) |=> (cnt_q == $past(cnt_q) + 1'b1))
        else $error("R2: commit did not add one cell");

endmodule

// File: rtl/utopia_rx_csr.sv
module utopia_rx_csr
    import utopia_rx_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_i,
    input  logic       rd_i,
    input  logic [7:0] wdata_i,
    input  logic       commit_i,
    input  logic       flush_done_i,
    output logic       early_o,
    output logic       multi_o,
    output logic       flush_o,
    output logic [7:0] rdata_o
);

    logic early_q;
    logic multi_q;
    logic flush_q;
    logic nocell_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            early_q  <= 1'b0;
            multi_q  <= 1'b0;
            flush_q  <= 1'b0;
            nocell_q <= 1'b1;
        end else begin
            if (wr_i) begin
                early_q <= wdata_i[CFG_EARLY_BIT];
                multi_q <= wdata_i[CFG_MULTI_BIT];
                if (wdata_i[CFG_FLUSH_BIT]) begin
                    flush_q <= 1'b1;
                end
            end
            if (flush_done_i) begin
                flush_q <= 1'b0;
            end
            if (commit_i) begin
                nocell_q <= 1'b0;
            end else if (rd_i) begin
                nocell_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata_o                 = '0;
        rdata_o[CFG_EARLY_BIT]  = early_q;
        rdata_o[CFG_MULTI_BIT]  = multi_q;
        rdata_o[CFG_FLUSH_BIT]  = flush_q;
        rdata_o[CFG_NOCELL_BIT] = nocell_q;
    end

    assign early_o = early_q;
    assign multi_o = multi_q;
    assign flush_o = flush_q;

    p_flush_selfclear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flush_q) |-> ##2 !flush_q)
        else $error("R10: flush bit did not clear itself");

    p_nocell_after_commit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_i |=> !nocell_q)
        else $error("R11: status bit still shows no cell after commit");

endmodule

// File: rtl/utopia_rx_reader.sv
module utopia_rx_reader
    import utopia_rx_pkg::*;
#(
    parameter int unsigned NCELLS        = 4,
    parameter int unsigned CELL_BYTES    = 53,
    parameter int unsigned HDR_BYTES     = 5,
    parameter int unsigned EARLY_PAYLOAD = 44,
    localparam int unsigned SLOT_W       = $clog2(NCELLS),
    localparam int unsigned IDX_W        = $clog2(CELL_BYTES),
    localparam int unsigned CNT_W        = $clog2(NCELLS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_ni,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              flush_req_i,
    input  logic              early_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              release_o,
    output logic              flush_done_o,
    output logic              avail_o,
    output logic              start_o
);

    localparam int unsigned EARLY_IDX = HDR_BYTES + EARLY_PAYLOAD - 1;

    rd_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              take;
    logic              last;
    logic              have_cell;
    logic              past_mark;

    always_comb begin
        have_cell = (cnt_i != '0);
        take      = !en_ni && !flush_req_i &&
                    ((state_q == RD_IDLE && have_cell) || state_q == RD_XFER);
        last      = take && (idx_q == IDX_W'(CELL_BYTES - 1));
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        slot_d  = slot_q;
        unique case (state_q)
            RD_IDLE: begin
                if (flush_req_i) begin
                    state_d = RD_FLUSH;
                end else if (take) begin
                    state_d = RD_XFER;
                    idx_d   = idx_q + 1'b1;
                end
            end
            RD_XFER: begin
                if (flush_req_i) begin
                    state_d = RD_FLUSH;
                end else if (last) begin
                    state_d = RD_IDLE;
                    idx_d   = '0;
                    slot_d  = slot_q + 1'b1;
                end else if (take) begin
                    idx_d = idx_q + 1'b1;
                end
            end
            RD_FLUSH: begin
                state_d = RD_IDLE;
                idx_d   = '0;
                slot_d  = '0;
            end
            default: begin
                state_d = RD_IDLE;
                idx_d   = '0;
                slot_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RD_IDLE;
            idx_q   <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            slot_q  <= slot_d;
        end
    end

    always_comb begin
        past_mark    = (state_q == RD_XFER) && (idx_q > IDX_W'(EARLY_IDX));
        release_o    = last;
        flush_done_o = (state_q == RD_FLUSH);
        start_o      = (state_q == RD_IDLE) && have_cell && !flush_req_i;
        slot_o       = slot_q;
        idx_o        = idx_q;
        if (flush_req_i || state_q == RD_FLUSH) begin
            avail_o = 1'b0;
        end else if (early_i) begin
            avail_o = (cnt_i > CNT_W'(1)) || (have_cell && !past_mark);
        end else begin
            avail_o = have_cell;
        end
    end

    p_hold_when_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == RD_XFER && en_ni && !flush_req_i) |=> (idx_q == $past(idx_q)))
        else $error("R5: byte position moved while enable was high");

    p_end_of_cell_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == RD_XFER && idx_q == IDX_W'(CELL_BYTES - 1) && !en_ni && !flush_req_i)
            |=> (state_q == RD_IDLE))
        else $error("R6: cell end did not return to idle");

    p_start_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_o && !en_ni) |=> !start_o)
        else $error("R3: start marker repeated after first byte");

    p_flush_one_cycle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == RD_FLUSH) |=> (state_q == RD_IDLE && idx_q == '0))
        else $error("R12: flush state did not return to idle");

endmodule

// File: rtl/utopia_rx_cellport.sv
module utopia_rx_cellport
    import utopia_rx_pkg::*;
#(
    parameter int unsigned NCELLS        = 4,
    parameter int unsigned CELL_BYTES    = 53,
    parameter int unsigned HDR_BYTES     = 5,
    parameter int unsigned EARLY_PAYLOAD = 44
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cell_wr_valid_i,
    input  logic [7:0] cell_wr_data_i,
    input  logic       rd_en_ni,
    output logic [7:0] rd_data_o,
    output logic       rd_start_o,
    output logic       rd_par_o,
    output logic       rd_oe_o,
    output logic       cell_avail_o,
    input  logic       cfg_wr_i,
    input  logic       cfg_rd_i,
    input  logic [7:0] cfg_wdata_i,
    output logic [7:0] cfg_rdata_o
);

    localparam int unsigned SLOT_W = $clog2(NCELLS);
    localparam int unsigned IDX_W  = $clog2(CELL_BYTES);
    localparam int unsigned CNT_W  = $clog2(NCELLS + 1);

    logic              early;
    logic              multi;
    logic              flush_req;
    logic              flush_done;
    logic              commit;
    logic              release_cell;
    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] rd_slot;
    logic [IDX_W-1:0]  rd_idx;
    logic [7:0]        rd_byte;

    utopia_rx_csr u_csr (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_i         (cfg_wr_i),
        .rd_i         (cfg_rd_i),
        .wdata_i      (cfg_wdata_i),
        .commit_i     (commit),
        .flush_done_i (flush_done),
        .early_o      (early),
        .multi_o      (multi),
        .flush_o      (flush_req),
        .rdata_o      (cfg_rdata_o)
    );

    utopia_rx_store #(
        .NCELLS     (NCELLS),
        .CELL_BYTES (CELL_BYTES),
        .DW         (8)
    ) u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_valid_i (cell_wr_valid_i),
        .wr_data_i  (cell_wr_data_i),
        .clear_i    (flush_done),
        .release_i  (release_cell),
        .rd_slot_i  (rd_slot),
        .rd_idx_i   (rd_idx),
        .rd_byte_o  (rd_byte),
        .cnt_o      (cnt),
        .commit_o   (commit)
    );

    utopia_rx_reader #(
        .NCELLS        (NCELLS),
        .CELL_BYTES    (CELL_BYTES),
        .HDR_BYTES     (HDR_BYTES),
        .EARLY_PAYLOAD (EARLY_PAYLOAD)
    ) u_reader (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_ni        (rd_en_ni),
        .cnt_i        (cnt),
        .flush_req_i  (flush_req),
        .early_i      (early),
        .slot_o       (rd_slot),
        .idx_o        (rd_idx),
        .release_o    (release_cell),
        .flush_done_o (flush_done),
        .avail_o      (cell_avail_o),
        .start_o      (rd_start_o)
    );

    always_comb begin
        rd_data_o = rd_byte;
        rd_par_o  = ~(^rd_byte);
        rd_oe_o   = !(multi && rd_en_ni);
    end

    p_avail_after_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit && !flush_req && !cfg_wr_i) |=> cell_avail_o)
        else $error("R2: committed cell not flagged as available");

    p_idle_during_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_req |-> !cell_avail_o)
        else $error("R10: cell flagged during flush");

endmodule

// File: tb/utopia_rx_cellport_bench.sv
module utopia_rx_cellport_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en_n = 1'b1;
    logic [7:0] rd_data;
    logic       rd_start;
    logic       rd_par;
    logic       rd_oe;
    logic       avail;
    logic       cfg_wr = 1'b0;
    logic       cfg_rd = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;

    int  n_checks = 0;
    int  n_bad = 0;
    bit  reported = 1'b0;
    bit  multi_mode = 1'b0;
    bit  stall_on = 1'b1;
    logic [7:0] salt [64];

    always #2.5 clk = ~clk;

    utopia_rx_cellport u_utopia_rx_cellport (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .cell_wr_valid_i (wr_valid),
        .cell_wr_data_i  (wr_data),
        .rd_en_ni        (rd_en_n),
        .rd_data_o       (rd_data),
        .rd_start_o      (rd_start),
        .rd_par_o        (rd_par),
        .rd_oe_o         (rd_oe),
        .cell_avail_o    (avail),
        .cfg_wr_i        (cfg_wr),
        .cfg_rd_i        (cfg_rd),
        .cfg_wdata_i     (cfg_wdata),
        .cfg_rdata_o     (cfg_rdata)
    );

    function automatic logic [7:0] exp_byte(input int id, input int k);
        return 8'(salt[id] + 8'(id * 29) + 8'(k * 7)) ^ 8'(k >> 3);
    endfunction

    function automatic logic odd_par(input logic [7:0] d);
        return ~(^d);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        cfg_wdata = v;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(output logic [7:0] v);
        cfg_rd = 1'b1;
        v = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic write_cell(input int id);
        for (int k = 0; k < 53; k++) begin
            wr_valid = 1'b1;
            wr_data  = exp_byte(id, k);
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    // Reads one cell; more = another whole cell remains queued, early = bit 0 set.
    task automatic read_cell(input int id, input bit more, input bit early);
        for (int k = 0; k < 53; k++) begin
            int stalls;
            stalls = stall_on ? int'($urandom_range(0, 2)) : 0;
            for (int s = 0; s < stalls; s++) begin
                rd_en_n = 1'b1;
                @(negedge clk);
                chk(rd_data == exp_byte(id, k), "R5 byte held while disabled",
                    rd_data, exp_byte(id, k));
                chk(rd_oe == !multi_mode, "R8 driver enable while disabled",
                    rd_oe, !multi_mode);
            end
            chk(rd_data == exp_byte(id, k), "R3 byte value", rd_data, exp_byte(id, k));
            chk(rd_start == (k == 0), "R3 start marker", rd_start, (k == 0));
            chk(rd_par == odd_par(rd_data), "R4 odd parity", rd_par, odd_par(rd_data));
            chk(avail == (more || !early || k <= 48),
                early ? "R7 early flag during cell" : "R6 flag during cell",
                avail, (more || !early || k <= 48));
            rd_en_n = 1'b0;
            @(negedge clk);
            chk(rd_oe == 1'b1, "R8 driver enable while reading", rd_oe, 1);
        end
        rd_en_n = 1'b1;
        chk(avail == more, early ? "R7 flag after cell" : "R6 flag after cell", avail, more);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1964));
        for (int i = 0; i < 64; i++) salt[i] = 8'($urandom);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(avail == 1'b0, "R1 flag after reset", avail, 0);
        chk(rd_oe == 1'b1, "R1 driver enable after reset", rd_oe, 1);
        chk(cfg_rdata == 8'h08, "R1 control byte after reset", cfg_rdata, 8'h08);

        // R2 visibility only after byte 53
        for (int k = 0; k < 52; k++) begin
            wr_valid = 1'b1;
            wr_data  = exp_byte(0, k);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        @(negedge clk);
        chk(avail == 1'b0, "R2 flag low with 52 bytes", avail, 0);
        wr_valid = 1'b1;
        wr_data  = exp_byte(0, 52);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(avail == 1'b1, "R2 flag high after byte 53", avail, 1);

        // R11 sticky status
        cfg_read(v);
        chk(v[3] == 1'b0, "R11 status after a cell", v[3], 0);
        cfg_read(v);
        chk(v[3] == 1'b1, "R11 status after read", v[3], 1);

        // R3 R4 R5 R6 standard read
        read_cell(0, 1'b0, 1'b0);

        // R3 order across three cells, standard mode
        write_cell(1); write_cell(2); write_cell(3);
        read_cell(1, 1'b1, 1'b0);
        read_cell(2, 1'b1, 1'b0);
        read_cell(3, 1'b0, 1'b0);

        // R9 capacity: fifth cell is discarded whole
        for (int i = 4; i < 9; i++) write_cell(i);
        for (int i = 4; i < 8; i++) read_cell(i, i < 7, 1'b0);
        @(negedge clk);
        chk(avail == 1'b0, "R9 dropped cell not present", avail, 0);
        write_cell(9);
        read_cell(9, 1'b0, 1'b0);

        // R7 early drop, single and with a queued cell
        cfg_write(8'h01);
        write_cell(10);
        read_cell(10, 1'b0, 1'b1);
        write_cell(11); write_cell(12);
        read_cell(11, 1'b1, 1'b1);
        read_cell(12, 1'b0, 1'b1);

        // R8 shared-bus driver release
        cfg_write(8'h02);
        multi_mode = 1'b1;
        @(negedge clk);
        chk(rd_oe == 1'b0, "R8 released with enable high", rd_oe, 0);
        write_cell(13);
        read_cell(13, 1'b0, 1'b0);
        cfg_write(8'h00);
        multi_mode = 1'b0;
        chk(rd_oe == 1'b1, "R8 driven in single mode", rd_oe, 1);

        // R10 R12 flush in the middle of a cell
        write_cell(14); write_cell(15);
        rd_en_n = 1'b0;
        repeat (10) @(negedge clk);
        rd_en_n = 1'b1;
        cfg_write(8'h04);
        chk(cfg_rdata[2] == 1'b1, "R10 flush bit set", cfg_rdata[2], 1);
        chk(avail == 1'b0, "R10 flag low during flush", avail, 0);
        @(negedge clk);
        chk(cfg_rdata[2] == 1'b1, "R10 flush bit second cycle", cfg_rdata[2], 1);
        @(negedge clk);
        chk(cfg_rdata[2] == 1'b0, "R10 flush bit cleared", cfg_rdata[2], 0);
        chk(avail == 1'b0, "R10 store empty after flush", avail, 0);
        write_cell(16);
        read_cell(16, 1'b0, 1'b0);
        chk(1'b1, "R12 fresh cell read from first byte", 1, 1);

        // random rounds
        for (int r = 0; r < 8; r++) begin
            int n;
            bit e;
            n = int'($urandom_range(1, 4));
            e = 1'($urandom_range(0, 1));
            cfg_write({7'd0, e});
            for (int i = 0; i < n; i++) write_cell(20 + r * 4 + i);
            for (int i = 0; i < n; i++) read_cell(20 + r * 4 + i, i < n - 1, e);
        end

        report();
    end

endmodule